// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Two predictors run side by side. The first keeps a 12-bit record of the most recent branch outcomes from the whole program and uses it to pick a 2-bit counter. The second works in two levels. A per-branch table, addressed by instruction address bits, holds each branch's own recent outcomes. That per-branch record then picks a 3-bit counter. A third table of 2-bit counters, addressed by the same global record, decides which of the two answers to use for each branch.

The front end gives the branch's word-address bits on the lookup port. In the same cycle it gets the final prediction, both component predictions and the selector decision. When the branch resolves, the back end puts the same address bits, the real outcome and the two component predictions it kept from lookup on the update port for one cycle. Both component predictors are then trained. The outcome is shifted into both the global record and that branch's local record. The selector moves only when exactly one of the two components was right.

Top module: `tbp_predictor`

## Requirements
- R1: After reset, every global counter holds 1 and every local counter holds 3, so both predict not taken. Every selector counter holds 1, which selects the local answer. The global record and all local records are zero.
- R2: The global prediction is taken exactly when the 2-bit counter selected by the current 12-bit global record is 2 or 3.
- R3: Each update trains the global counter at the pre-update global record. The counter goes up on taken and down on not taken, and it saturates at 0 and 3.
- R4: Each update shifts the outcome (1 = taken) into bit 0 of the global record, so bit i holds the outcome of the (i+1)-th most recent branch.
- R5: The local record table has 1024 entries of 10 bits, addressed by PC bits [11:2]. An update shifts the outcome into bit 0 of the entry at the update address only.
- R6: The local prediction is taken exactly when the 3-bit counter selected by the branch's 10-bit local record is 4 or more. On update, the counter selected by the pre-update record of the update address moves toward the outcome and saturates at 0 and 7.
- R7: The selector decision is the upper bit of the 2-bit selector counter at the current global record. A value of 2 or 3 chooses the global answer.
- R8: On update, if both component predictions were right, or both were wrong, the selector counter does not change. Otherwise it moves one step toward the component that was right, saturating at 0 and 3.
- R9: The final prediction equals the global prediction when the selector chooses global, and the local prediction otherwise.
- R10: A lookup in the same cycle as an update sees the state from before that update. The update shows up on the lookup outputs from the next cycle on.
- R11: In a cycle without an update, no counter and no history changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc_idx | input | 10 | Lookup branch address, PC bits [11:2] |
| pred_taken | output | 1 | Final prediction, 1 = taken |
| pred_global | output | 1 | Global-history component prediction |
| pred_local | output | 1 | Local-history component prediction |
| pred_use_global | output | 1 | Selector decision, 1 = global answer used |
| upd_valid | input | 1 | Update strobe for one resolved branch |
| upd_pc_idx | input | 10 | Resolved branch address, PC bits [11:2] |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| upd_pred_global | input | 1 | Global component prediction kept from lookup |
| upd_pred_local | input | 1 | Local component prediction kept from lookup |

## Verification
Long runs of one outcome drive the counters into saturation at both ends. A design that wraps around instead of clamping would flip its predictions after a long loop. Component predictions are fed both in agreement and in disagreement with the outcome. This exposes a selector that moves when both components agree, or that moves toward the wrong one, because later lookups at those history values would then take the other answer. Updates are applied to one address while lookups go to another, and the same address is looked up in the update cycle. This catches a history written to the wrong entry, a local counter trained through the post-update record, and an update that becomes visible one cycle early.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  // Default geometry of the predictor
  localparam int GHIST_W_D   = 12;  // global record length, global/selector index
  localparam int LHT_IDX_W_D = 10;  // local record table address width
  localparam int LHIST_W_D   = 10;  // local record length, local counter index
  localparam int GCTR_W_D    = 2;
  localparam int LCTR_W_D    = 3;
  localparam int CHS_W_D     = 2;

  // Reset value for a counter that sits one step below its taken threshold
  function automatic int unsigned weak_low(input int ctr_w);
    return (1 << (ctr_w - 1)) - 1;
  endfunction
endpackage

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table #(
  parameter int          IDX_W   = 12,
  parameter int          CTR_W   = 2,
  parameter int unsigned RST_VAL = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_msb,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  localparam int             DEPTH = 1 << IDX_W;
  localparam logic [CTR_W-1:0] C_RST = CTR_W'(RST_VAL);
  localparam logic [CTR_W-1:0] C_MAX = {CTR_W{1'b1}};

  logic [CTR_W-1:0] mem [DEPTH];
  logic [CTR_W-1:0] cur_val;
  logic [CTR_W-1:0] nxt_val;
  logic             do_wr;

  always_comb begin
    cur_val = mem[wr_idx];
    nxt_val = cur_val;
    do_wr   = 1'b0;
    if (wr_en) begin
      if (wr_up) begin
        if (cur_val != C_MAX) begin
          nxt_val = cur_val + CTR_W'(1);
          do_wr   = 1'b1;
        end
      end else begin
        if (cur_val != '0) begin
          nxt_val = cur_val - CTR_W'(1);
          do_wr   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= C_RST;
    end else if (do_wr) begin
      mem[wr_idx] <= nxt_val;
    end
  end

  assign rd_msb = mem[rd_idx][CTR_W-1];
endmodule

// File: rtl/tbp_hist_table.sv
module tbp_hist_table #(
  parameter int IDX_W  = 10,
  parameter int HIST_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [HIST_W-1:0] rd_hist,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_bit,
  output logic [HIST_W-1:0] wr_hist
);
  localparam int DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] mem [DEPTH];
  logic [HIST_W-1:0] nxt_hist;

  assign wr_hist = mem[wr_idx];
  assign rd_hist = mem[rd_idx];

  always_comb begin
    nxt_hist = {wr_hist[HIST_W-2:0], wr_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= nxt_hist;
    end
  end
endmodule

// File: rtl/tbp_ghist.sv
module tbp_ghist #(
  parameter int HIST_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              shift_bit,
  output logic [HIST_W-1:0] hist
);
  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_d;

  always_comb begin
    hist_d = {hist_q[HIST_W-2:0], shift_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hist_q <= '0;
    else if (shift_en) hist_q <= hist_d;
  end

  assign hist = hist_q;
endmodule

// File: rtl/tbp_predictor.sv
module tbp_predictor
  import tbp_pkg::*;
#(
  parameter int GHIST_W   = GHIST_W_D,
  parameter int LHT_IDX_W = LHT_IDX_W_D,
  parameter int LHIST_W   = LHIST_W_D,
  parameter int GCTR_W    = GCTR_W_D,
  parameter int LCTR_W    = LCTR_W_D,
  parameter int CHS_W     = CHS_W_D
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LHT_IDX_W-1:0] lk_pc_idx,
  output logic                 pred_taken,
  output logic                 pred_global,
  output logic                 pred_local,
  output logic                 pred_use_global,
  input  logic                 upd_valid,
  input  logic [LHT_IDX_W-1:0] upd_pc_idx,
  input  logic                 upd_taken,
  input  logic                 upd_pred_global,
  input  logic                 upd_pred_local
);
  localparam int unsigned GCTR_RST = weak_low(GCTR_W);
  localparam int unsigned LCTR_RST = weak_low(LCTR_W);
  localparam int unsigned CHS_RST  = weak_low(CHS_W);  // weakly local

  logic [GHIST_W-1:0] ghist;
  logic [LHIST_W-1:0] lk_lhist;
  logic [LHIST_W-1:0] upd_lhist;
  logic               g_ok;
  logic               l_ok;
  logic               chs_move;

  always_comb begin
    g_ok     = (upd_pred_global == upd_taken);
    l_ok     = (upd_pred_local == upd_taken);
    chs_move = upd_valid && (g_ok != l_ok);
  end

  tbp_ghist #(.HIST_W(GHIST_W)) u_ghist (
    .clk(clk), .rst_n(rst_n),
    .shift_en(upd_valid), .shift_bit(upd_taken),
    .hist(ghist)
  );

  tbp_hist_table #(.IDX_W(LHT_IDX_W), .HIST_W(LHIST_W)) u_lhist (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_pc_idx), .rd_hist(lk_lhist),
    .wr_en(upd_valid), .wr_idx(upd_pc_idx), .wr_bit(upd_taken),
    .wr_hist(upd_lhist)
  );

  tbp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(GCTR_W), .RST_VAL(GCTR_RST)) u_gctr (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(ghist), .rd_msb(pred_global),
    .wr_en(upd_valid), .wr_idx(ghist), .wr_up(upd_taken)
  );

  tbp_ctr_table #(.IDX_W(LHIST_W), .CTR_W(LCTR_W), .RST_VAL(LCTR_RST)) u_lctr (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_lhist), .rd_msb(pred_local),
    .wr_en(upd_valid), .wr_idx(upd_lhist), .wr_up(upd_taken)
  );

  tbp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(CHS_W), .RST_VAL(CHS_RST)) u_chs (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(ghist), .rd_msb(pred_use_global),
    .wr_en(chs_move), .wr_idx(ghist), .wr_up(g_ok)
  );

  always_comb begin
    pred_taken = pred_use_global ? pred_global : pred_local;
  end
endmodule

// File: rtl/tbp_predictor_chk.sv
module tbp_predictor_chk #(
  parameter int GHIST_W   = 12,
  parameter int LHT_IDX_W = 10
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [LHT_IDX_W-1:0] lk_pc_idx,
  input logic                 pred_taken,
  input logic                 pred_global,
  input logic                 pred_local,
  input logic                 pred_use_global,
  input logic                 upd_valid,
  input logic                 upd_taken,
  input logic [GHIST_W-1:0]   ghist
);
  // R9
  agree_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_global == pred_local) |-> (pred_taken == pred_global));

  // R4
  ghist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> (ghist == {$past(ghist[GHIST_W-2:0]), $past(upd_taken)}));

  // R11
  ghist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(ghist));

  // R11
  idle_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_valid ##1 $stable(lk_pc_idx)) |->
      $stable({pred_taken, pred_global, pred_local, pred_use_global}));
endmodule

bind tbp_predictor tbp_predictor_chk #(.GHIST_W(GHIST_W), .LHT_IDX_W(LHT_IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_pc_idx(lk_pc_idx),
  .pred_taken(pred_taken), .pred_global(pred_global), .pred_local(pred_local),
  .pred_use_global(pred_use_global), .upd_valid(upd_valid), .upd_taken(upd_taken),
  .ghist(ghist)
);

// File: tb/tbp_predictor_tb_top.sv
`timescale 1ns/1ps
module tbp_predictor_tb_top;
  localparam int GH_N  = 4096;
  localparam int LHT_N = 1024;
  localparam int LC_N  = 1024;

  logic       clk;
  logic       rst_n;
  logic [9:0] lk_pc_idx;
  logic       pred_taken, pred_global, pred_local, pred_use_global;
  logic       upd_valid;
  logic [9:0] upd_pc_idx;
  logic       upd_taken, upd_pred_global, upd_pred_local;

  tbp_predictor dut_i (
    .clk(clk), .rst_n(rst_n), .lk_pc_idx(lk_pc_idx),
    .pred_taken(pred_taken), .pred_global(pred_global), .pred_local(pred_local),
    .pred_use_global(pred_use_global),
    .upd_valid(upd_valid), .upd_pc_idx(upd_pc_idx), .upd_taken(upd_taken),
    .upd_pred_global(upd_pred_global), .upd_pred_local(upd_pred_local)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Behavioural reference state
  int gm  [GH_N];
  int chm [GH_N];
  int lcm [LC_N];
  int lhm [LHT_N];
  int gh;

  int    n_checks;
  int    n_errors;
  bit    done;
  string phase;

  task automatic model_reset();
    for (int i = 0; i < GH_N; i++) begin gm[i] = 1; chm[i] = 1; end
    for (int i = 0; i < LC_N; i++) lcm[i] = 3;
    for (int i = 0; i < LHT_N; i++) lhm[i] = 0;
    gh = 0;
  endtask

  function automatic bit m_glob();
    return gm[gh] >= 2;
  endfunction
  function automatic bit m_loc(input int pc);
    return lcm[lhm[pc]] >= 4;
  endfunction

  function automatic int sat(input int v, input int up, input int mx);
    if (up != 0) return (v < mx) ? v + 1 : v;
    return (v > 0) ? v - 1 : v;
  endfunction

  task automatic model_update(input int pc, input bit t, input bit pg, input bit pl);
    int li;
    li = lhm[pc];
    gm[gh]  = sat(gm[gh], t, 3);
    lcm[li] = sat(lcm[li], t, 7);
    if ((pg == t) != (pl == t)) chm[gh] = sat(chm[gh], (pg == t), 3);
    lhm[pc] = ((lhm[pc] << 1) | int'(t)) & (LHT_N - 1);
    gh      = ((gh << 1) | int'(t)) & (GH_N - 1);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0b expected %0b", phase, tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, compare after settling, then advance model
  task automatic step(input int lpc, input bit v, input int upc, input bit t,
                      input bit follow, input bit pg_r, input bit pl_r);
    bit eg, el, eu, pg, pl;
    @(negedge clk);
    pg = follow ? m_glob()   : pg_r;
    pl = follow ? m_loc(upc) : pl_r;
    lk_pc_idx       = 10'(lpc);
    upd_valid       = v;
    upd_pc_idx      = 10'(upc);
    upd_taken       = t;
    upd_pred_global = pg;
    upd_pred_local  = pl;
    #1;
    eg = m_glob();
    el = m_loc(lpc);
    eu = chm[gh] >= 2;
    chk("R2 global", pred_global, eg);
    chk("R6 local", pred_local, el);
    chk("R7 select", pred_use_global, eu);
    chk("R9 final", pred_taken, eu ? eg : el);
    if (v) model_update(upc, t, pg, pl);
  endtask

  initial begin
    int pc;
    n_checks = 0; n_errors = 0; done = 0;
    phase = "R1";
    rst_n = 1'b0;
    lk_pc_idx = '0; upd_valid = 1'b0; upd_pc_idx = '0;
    upd_taken = 1'b0; upd_pred_global = 1'b0; upd_pred_local = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, everything not taken and local selected
    for (int i = 0; i < 8; i++) step(i * 97, 0, 0, 0, 0, 0, 0);

    // R3 / R4: long taken run then long not-taken run saturates global counters
    phase = "R3";
    for (int i = 0; i < 40; i++) step(5, 1, 5, 1, 1, 0, 0);
    phase = "R4";
    for (int i = 0; i < 40; i++) step(5, 1, 5, 0, 1, 0, 0);

    // R5 / R6: per-branch patterns on two addresses, lookups at a third
    phase = "R5";
    for (int i = 0; i < 300; i++) begin
      step(17, 1, 17, (i % 3) != 2, 1, 0, 0);
      step(300, 1, 300, i[0], 1, 0, 0);
      step(999, 0, 0, 0, 0, 0, 0);
    end
    phase = "R6";
    for (int i = 0; i < 120; i++) step(17, 1, 17, 1, 1, 0, 0);

    // R8: arbitrary component predictions, agreeing and disagreeing
    phase = "R8";
    for (int i = 0; i < 600; i++) begin
      pc = $urandom_range(15);
      step(pc, 1, pc, $urandom_range(1), 0, $urandom_range(1), $urandom_range(1));
    end

    // R11: idle cycles, no state may move
    phase = "R11";
    for (int i = 0; i < 200; i++) step($urandom_range(15), 0, $urandom_range(15), 1, 0, 1, 0);

    // R10: same-cycle lookup/update, mixed traffic
    phase = "R10";
    for (int i = 0; i < 1500; i++) begin
      pc = $urandom_range(31);
      step(($urandom_range(1) != 0) ? pc : int'($urandom_range(31)),
           $urandom_range(3) != 0, pc, $urandom_range(1),
           $urandom_range(1), $urandom_range(1), $urandom_range(1));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #150000;
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL %s watchdog: actual hung expected finished", phase);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule